// File: doc/BRIEF.md
# End-of-Conversion Serial ADC Reader

This controller fetches one conversion result from a serial-output analog-to-digital converter each time the converter finishes a conversion. It watches the converter's busy line through a two-flop synchronizer. When that line falls, meaning the conversion is complete, the controller drives a burst of exactly 16 serial clock pulses. Between bursts the serial clock is held low, so it runs only while a result is being read.

The converter moves to its next data bit after each rising serial clock edge. The controller samples the data line on each falling edge, most significant bit first. The converter holds a 14-bit two's-complement code inside a 16-bit frame. The two leading bits are dropped, and the 14-bit code is sign-extended onto a 16-bit parallel result.

The result is handed over with a valid/ready handshake. The serial clock's high and low phases are each a programmable number of system clocks long. If a new end of conversion arrives while the previous result is still waiting, a sticky overrun flag is set and the older result is kept.

Top module: `adc_eoc_reader`

## Requirements
- R1: A read starts only on a falling edge of the synchronized `busy_i`. A rising edge, or a steady high or low level, starts no read and produces no serial clock pulse.
- R2: `sclk_o` is low whenever no read is in progress.
- R3: Each read produces exactly 16 rising edges on `sclk_o`, then stops.
- R4: Each high phase of `sclk_o` lasts exactly `HALF_CYCLES` system clocks, and so does each low phase inside a read.
- R5: Each high phase of `sclk_o` lasts at least 110 ns at a system clock of `SYS_CLK_MHZ`.
- R6: `sdata_i` is sampled on each falling edge of `sclk_o`, and the first bit sampled is bit 15 of the frame. Frame bits 15 and 14 are ignored. `result_o` equals frame bits 13..0 with bit 13 copied into result bits 15 and 14.
- R7: `result_valid_o` rises on the clock after the 16th falling edge. It then stays high, with `result_o` unchanged, until a cycle in which `result_ready_i` is high. It is low on the clock after that cycle.
- R8: A `busy_i` falling edge is an overrun if it arrives while a read is running, or while `result_valid_o` is high and `result_ready_i` is low. An overrun sets `overrun_o`, launches no read and keeps the older result. `overrun_o` stays set until reset.
- R9: While `rst_ni` is low and after it is released, `sclk_o`, `result_valid_o` and `overrun_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | Converter busy line; a falling edge means the result is ready |
| sdata_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Gated serial clock to the converter |
| result_o | output | 16 | Sign-extended conversion result |
| result_valid_o | output | 1 | Result available |
| result_ready_i | input | 1 | Consumer accepts the result |
| overrun_o | output | 1 | Sticky flag: an end of conversion was dropped |

## Verification
The bench builds the block with `HALF_CYCLES` = 6 and `SYS_CLK_MHZ` = 50. This gives a 120 ns high phase, the shortest legal setting at this clock, so the R5 margin is tight and a shortened phase would break it. A 12-cycle bit period keeps a full read near 200 cycles. That leaves room to test overrun, back-to-back conversions and held-off handshakes within a short run. The converter model presents new bits a few nanoseconds after each rising serial edge, which reproduces the access delay ahead of the falling-edge sample point.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int unsigned FRAME_W = 16;
  localparam int unsigned CODE_W  = 14;
  localparam int unsigned MIN_HIGH_NS = 110;

  function automatic logic [FRAME_W-1:0] sext_code(input logic [FRAME_W-1:0] frame);
    return {{(FRAME_W-CODE_W){frame[CODE_W-1]}}, frame[CODE_W-1:0]};
  endfunction
endpackage

// File: rtl/busy_edge_det.sv
module busy_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  output logic busy_s_o,
  output logic eoc_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= busy_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign busy_s_o = s2_q;
  assign eoc_o    = s3_q & ~s2_q;
endmodule

// File: rtl/sclk_gen.sv
module sclk_gen #(
  parameter int unsigned HALF_CYCLES = 6,
  parameter int unsigned PULSES      = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o,
  output logic sclk_o,
  output logic sample_o,
  output logic done_o
);
  localparam int unsigned HW = $clog2(HALF_CYCLES + 1);
  localparam int unsigned PW = $clog2(PULSES + 1);
  localparam logic [HW-1:0] HALF_LAST  = HW'(HALF_CYCLES - 1);
  localparam logic [PW-1:0] PULSE_LAST = PW'(PULSES - 1);

  logic          active_q, sclk_q;
  logic [HW-1:0] hcnt_q;
  logic [PW-1:0] pcnt_q;
  logic          phase_end, fall, last;

  assign phase_end = active_q && (hcnt_q == HALF_LAST);
  assign fall      = phase_end && sclk_q;
  assign last      = fall && (pcnt_q == PULSE_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      hcnt_q   <= '0;
      pcnt_q   <= '0;
    end else if (!active_q) begin
      if (start_i) begin
        active_q <= 1'b1;
        sclk_q   <= 1'b0;
        hcnt_q   <= '0;
        pcnt_q   <= '0;
      end
    end else if (phase_end) begin
      hcnt_q <= '0;
      sclk_q <= ~sclk_q;
      if (fall) pcnt_q <= pcnt_q + 1'b1;
      if (last) active_q <= 1'b0;
    end else begin
      hcnt_q <= hcnt_q + 1'b1;
    end
  end

  assign active_o = active_q;
  assign sclk_o   = sclk_q;
  assign sample_o = fall;
  assign done_o   = last;
endmodule

// File: rtl/rx_shift.sv
module rx_shift #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_i,
  input  logic             sdata_i,
  output logic [WIDTH-1:0] word_next_o
);
  logic [WIDTH-1:0] sh_q;

  // word including the bit sampled this cycle
  assign word_next_o = {sh_q[WIDTH-2:0], sdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sh_q <= '0;
    else if (sample_i) sh_q <= word_next_o;
  end
endmodule

// File: rtl/adc_eoc_reader.sv
module adc_eoc_reader
  import adc_rd_pkg::*;
#(
  parameter int unsigned HALF_CYCLES = 6,
  parameter int unsigned SYS_CLK_MHZ = 50
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               busy_i,
  input  logic               sdata_i,
  output logic               sclk_o,
  output logic [FRAME_W-1:0] result_o,
  output logic               result_valid_o,
  input  logic               result_ready_i,
  output logic               overrun_o
);
  logic busy_s, eoc, rd_active, sample, done, start, drop;
  logic [FRAME_W-1:0] word_next, result_q;
  logic valid_q, ovr_q;

  busy_edge_det u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .busy_i  (busy_i),
    .busy_s_o(busy_s),
    .eoc_o   (eoc)
  );

  sclk_gen #(.HALF_CYCLES(HALF_CYCLES), .PULSES(FRAME_W)) u_sclk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .active_o(rd_active),
    .sclk_o  (sclk_o),
    .sample_o(sample),
    .done_o  (done)
  );

  rx_shift #(.WIDTH(FRAME_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sample_i   (sample),
    .sdata_i    (sdata_i),
    .word_next_o(word_next)
  );

  // a result accepted this cycle frees the slot for a new read
  assign start = eoc && !rd_active && (!valid_q || result_ready_i);
  assign drop  = eoc && !start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      valid_q  <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      if (done) begin
        result_q <= sext_code(word_next);
        valid_q  <= 1'b1;
      end else if (result_ready_i) begin
        valid_q  <= 1'b0;
      end
      if (drop) ovr_q <= 1'b1;
    end
  end

  assign result_o       = result_q;
  assign result_valid_o = valid_q;
  assign overrun_o      = ovr_q;
endmodule

// File: rtl/adc_eoc_reader_chk.sv
module adc_eoc_reader_chk #(
  parameter int unsigned SYS_CLK_MHZ = 50
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_s_i,
  input logic        rd_active_i,
  input logic        sclk_i,
  input logic        valid_i,
  input logic        ready_i,
  input logic [15:0] result_i,
  input logic        overrun_i
);
  logic sclk_d, act_d;
  int unsigned pulse_cnt, high_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d    <= 1'b0;
      act_d     <= 1'b0;
      pulse_cnt <= 0;
      high_cnt  <= 0;
    end else begin
      sclk_d <= sclk_i;
      act_d  <= rd_active_i;
      if (rd_active_i && !act_d)  pulse_cnt <= 0;
      else if (sclk_i && !sclk_d) pulse_cnt <= pulse_cnt + 1;
      if (sclk_i) high_cnt <= high_cnt + 1;
      else        high_cnt <= 0;
    end
  end

  a_r1_start_after_eoc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_active_i && !act_d) |-> !busy_s_i);

  a_r2_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_active_i |-> !sclk_i);

  a_r3_sixteen_pulses: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_i) |-> (pulse_cnt == 16));

  a_r5_high_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_d && !sclk_i) |-> (high_cnt * 1000 >= 110 * SYS_CLK_MHZ));

  a_r7_valid_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !ready_i) |=> (valid_i && $stable(result_i)));

  a_r8_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_i |=> overrun_i);
endmodule

bind adc_eoc_reader adc_eoc_reader_chk #(.SYS_CLK_MHZ(SYS_CLK_MHZ)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_s_i   (busy_s),
  .rd_active_i(rd_active),
  .sclk_i     (sclk_o),
  .valid_i    (result_valid_o),
  .ready_i    (result_ready_i),
  .result_i   (result_o),
  .overrun_i  (overrun_o)
);

// File: tb/adc_eoc_reader_tb.sv
`timescale 1ns/1ps
module adc_eoc_reader_tb;
  localparam int HALF = 6;
  localparam int MHZ  = 50;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic busy_i = 1'b0;
  logic sdata_i = 1'b0;
  logic ready_i = 1'b0;
  logic sclk_o, valid_o, overrun_o;
  logic [15:0] result_o;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int base = 0;
  int hi_run = 0;
  int last_hi = 0;
  logic [15:0] adc_word = '0;

  // {raw frame, expected result}
  localparam logic [31:0] VEC [8] = '{
    {16'h0000, 16'h0000}, {16'h1FFF, 16'h1FFF}, {16'h2000, 16'hE000},
    {16'h3FFF, 16'hFFFF}, {16'h2AAA, 16'hEAAA}, {16'h1555, 16'h1555},
    {16'hC001, 16'h0001}, {16'hA001, 16'hE001}
  };

  always #10 clk = ~clk;

  adc_eoc_reader #(.HALF_CYCLES(HALF), .SYS_CLK_MHZ(MHZ)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .busy_i(busy_i), .sdata_i(sdata_i),
    .sclk_o(sclk_o), .result_o(result_o), .result_valid_o(valid_o),
    .result_ready_i(ready_i), .overrun_o(overrun_o)
  );

  // converter model: next bit after each rising serial edge, with access delay
  always @(posedge sclk_o) begin
    #3;
    sdata_i = adc_word[4'(15 - (pulses - base))];
    pulses = pulses + 1;
  end

  always @(posedge clk) begin
    if (sclk_o) hi_run <= hi_run + 1;
    else if (hi_run != 0) begin
      last_hi <= hi_run;
      hi_run <= 0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic convert(input logic [15:0] frame);
    @(negedge clk) busy_i = 1'b1;
    repeat (20) @(negedge clk);
    adc_word = frame;
    base = pulses;
    busy_i = 1'b0;
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 1000; i++) begin
      if (valid_o) return;
      @(negedge clk);
    end
  endtask

  initial begin
    #4_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int p0;
    // R9 reset state
    repeat (3) @(negedge clk);
    check("R9 sclk", sclk_o, 0);
    check("R9 valid", valid_o, 0);
    check("R9 overrun", overrun_o, 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    check("R9 after release", {sclk_o, valid_o, overrun_o}, 0);

    // vector table
    for (int v = 0; v < 8; v++) begin
      p0 = pulses;
      convert(VEC[v][31:16]);
      wait_valid();
      check("R7 valid", valid_o, 1);
      check("R6 result", result_o, VEC[v][15:0]);
      check("R3 pulses", pulses - p0, 16);
      check("R2 idle low", sclk_o, 0);
      check("R4 high phase", last_hi, HALF);
      @(negedge clk) ready_i = 1'b1;
      @(negedge clk) ready_i = 1'b0;
      check("R7 valid cleared", valid_o, 0);
    end
    check("R5 min high ns", (last_hi * 1000 / MHZ >= 110) ? 1 : 0, 1);

    // R1: rising edge and steady levels start nothing
    p0 = pulses;
    @(negedge clk) busy_i = 1'b1;
    repeat (60) @(negedge clk);
    check("R1 no read on high", pulses - p0, 0);
    check("R1 sclk low", sclk_o, 0);
    busy_i = 1'b0;
    wait_valid();
    check("R1 one read per fall", pulses - p0, 16);
    @(negedge clk) ready_i = 1'b1;
    @(negedge clk) ready_i = 1'b0;
    repeat (100) @(negedge clk);
    check("R1 steady low no read", pulses - p0, 16);

    // R7: held off, then ready already high
    convert(16'h0123);
    wait_valid();
    repeat (10) @(negedge clk);
    check("R7 held valid", valid_o, 1);
    check("R7 held result", result_o, 16'h0123);
    ready_i = 1'b1;
    convert(16'h2345);
    wait_valid();
    check("R6 result ready-high", result_o, 16'hE345);
    @(negedge clk);
    check("R7 one-cycle valid", valid_o, 0);
    ready_i = 1'b0;

    // R8 overrun
    convert(16'h0555);
    wait_valid();
    p0 = pulses;
    convert(16'h1AAA);
    repeat (250) @(negedge clk);
    check("R8 overrun set", overrun_o, 1);
    check("R8 no read", pulses - p0, 0);
    check("R8 older kept", result_o, 16'h0555);
    @(negedge clk) ready_i = 1'b1;
    @(negedge clk) ready_i = 1'b0;
    repeat (5) @(negedge clk);
    check("R8 sticky", overrun_o, 1);

    // R9 reset clears overrun
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 overrun cleared", overrun_o, 0);
    rst_ni = 1'b1;
    convert(16'h3000);
    wait_valid();
    check("R6 after reset", result_o, 16'hF000);
    check("R8 no overrun", overrun_o, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule